// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block sits in front of a small word-addressed memory that several requesters share. Each requester has its own request channel: a valid/ready handshake that carries an opcode, a word address and write data. Each requester also has a response strobe. All requesters share one response data bus. Four operations exist: plain load, plain store, linked load and conditional store. A central arbiter accepts at most one request per cycle. A table of reservations decides every conditional store, with one reservation per requester holding an armed bit and a word address.

A linked load reads the word like a load and arms the caller's reservation on that word. A later conditional store from the same requester writes only while that reservation is still armed on the same word. Any write by another requester to the reserved word disarms the reservation. Software can build a mutex from this: spin on a linked load until the word reads 0, then conditionally store 1, and retry on status 0.

The success decision uses shared state. A conditional store therefore stalls the whole front end for `SC_WAIT` cycles before its status comes back. While it stalls, no other request is accepted.

Top module: `resv_mem_front`

## Requirements
- R1: A LOAD (opcode 0) returns the addressed word on `rsp_data`, with the caller's bit of `rsp_valid` high, in the cycle after the request is accepted. A STORE (opcode 1) writes the word, and its response, in the same cycle position, carries zero.
- R2: A LINK (opcode 2) returns the word in the same way as a LOAD. It also arms the caller's reservation on that address.
- R3: A COND (opcode 3) whose caller holds an armed reservation on the same address writes the word and returns status 1.
- R4: A COND whose caller has no armed reservation, or holds one on a different address, leaves memory unchanged and returns status 0.
- R5: Every COND, successful or not, disarms the caller's reservation. An immediately repeated COND therefore fails.
- R6: A STORE, or a successful COND, disarms every other requester's reservation on the written word. A requester's own plain STORE leaves its own reservation untouched.
- R7: A new LINK replaces the caller's earlier reservation, because each requester holds at most one reservation.
- R8: At most one `req_ready` bit is high, and only toward a requester whose valid is high. Competing requests are accepted one per cycle in rotating order, starting after the last accepted requester; after reset the search starts at requester 0.
- R9: After a COND is accepted, no request is accepted and no response appears for `SC_WAIT` cycles. Its status arrives `SC_WAIT + 1` cycles after acceptance.
- R10: While reset is asserted every `req_ready` bit is low. Reset disarms all reservations and clears the memory to zero.
- R11: When all requesters contend for a mutex word (0 free, 1 held) with LINK/COND sequences that overlap, exactly one COND succeeds in each round.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | N_REQ | Request valid, one bit per requester |
| req_ready | output | N_REQ | Request accepted this cycle, one bit per requester |
| req_op | input | 2*N_REQ | Opcode per requester: 0 LOAD, 1 STORE, 2 LINK, 3 COND |
| req_addr | input | N_REQ*ADDR_W | Word address per requester |
| req_wdata | input | N_REQ*DATA_W | Write data per requester |
| rsp_valid | output | N_REQ | One-cycle response strobe per requester |
| rsp_data | output | DATA_W | Read data or conditional status, shared by all requesters |

## Verification
Two functions can collide in the same cycle. The arbiter's choice among several valid requests decides the order of reservation updates, so a conditional store racing a store or another conditional store on the same word gets its outcome from that grant order. The bench provokes this with directed sets and random sets in which several requesters raise valid in the same cycle on a four-word address range, including a full mutex contention. A bench model predicts the grant from the rotation pointer and the reservation effects from the requirements. It then compares every ready vector, response strobe, returned word and status against that model.

// File: rtl/resv_pkg.sv
package resv_pkg;
   typedef enum logic [1:0] {
      OPC_LOAD  = 2'd0,
      OPC_STORE = 2'd1,
      OPC_LINK  = 2'd2,
      OPC_COND  = 2'd3
   } opc_e;
endpackage

// File: rtl/grant_rr.sv
// One-hot grant among requesters. Variant chosen by ROUND_ROBIN.
module grant_rr #(
   parameter int N           = 4,
   parameter bit ROUND_ROBIN = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] req,
   input  logic         adv,
   output logic [N-1:0] gnt
);
   timeunit 1ns; timeprecision 1ps;

   localparam int IW = (N > 1) ? $clog2(N) : 1;

   if (N < 2) begin : g_bad_n
      $error("grant_rr: N must be at least 2");
   end

   if (ROUND_ROBIN) begin : g_rr
      logic [IW-1:0] last_q;
      logic [IW-1:0] gidx;

      always_comb begin
         gnt = '0;
         // walk from farthest to nearest so the nearest requester wins
         for (int k = N; k >= 1; k--) begin
            automatic int j = (int'(last_q) + k) % N;
            if (req[j]) begin
               gnt    = '0;
               gnt[j] = 1'b1;
            end
         end
      end

      always_comb begin
         gidx = '0;
         for (int k = 0; k < N; k++) begin
            if (gnt[k]) gidx = IW'(k);
         end
      end

      always_ff @(posedge clk) begin
         if (!rst_n)   last_q <= IW'(N - 1);
         else if (adv) last_q <= gidx;
      end
   end else begin : g_fixed
      always_comb begin
         gnt = '0;
         for (int k = N - 1; k >= 0; k--) begin
            if (req[k]) begin
               gnt    = '0;
               gnt[k] = 1'b1;
            end
         end
      end
   end

   a_r8_grant_subset: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt & ~req) == '0);
   a_r8_grant_when_asked: assert property (@(posedge clk) disable iff (!rst_n)
      (req != '0) |-> $onehot(gnt));
endmodule

// File: rtl/resv_table.sv
// Per-requester reservation state and the conditional-store decision.
module resv_table
   import resv_pkg::*;
#(
   parameter int N  = 4,
   parameter int AW = 4,
   parameter int IW = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go,
   input  logic [IW-1:0] id,
   input  opc_e          op,
   input  logic [AW-1:0] addr,
   output logic          pass
);
   timeunit 1ns; timeprecision 1ps;

   if ((1 << IW) < N) begin : g_bad_iw
      $error("resv_table: IW too narrow for N");
   end

   logic [N-1:0]  armed_q;
   logic [AW-1:0] tag_q [N];
   logic          writes;

   assign pass   = armed_q[id] && (tag_q[id] == addr);
   assign writes = go && ((op == OPC_STORE) || ((op == OPC_COND) && pass));

   for (genvar r = 0; r < N; r++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            armed_q[r] <= 1'b0;
            tag_q[r]   <= '0;
         end else if (go) begin
            if (id == IW'(r)) begin
               if (op == OPC_LINK) begin
                  armed_q[r] <= 1'b1;
                  tag_q[r]   <= addr;
               end else if (op == OPC_COND) begin
                  armed_q[r] <= 1'b0;
               end
            end else if (writes && armed_q[r] && (tag_q[r] == addr)) begin
               armed_q[r] <= 1'b0;
            end
         end
      end
   end

   a_r2_link_arms: assert property (@(posedge clk) disable iff (!rst_n)
      (go && op == OPC_LINK) |=> (armed_q[$past(id)] && tag_q[$past(id)] == $past(addr)));
   a_r5_cond_disarms_own: assert property (@(posedge clk) disable iff (!rst_n)
      (go && op == OPC_COND) |=> !armed_q[$past(id)]);
endmodule

// File: rtl/word_store.sv
// Word memory, one synchronous write port, one combinational read port.
module word_store #(
   parameter int AW = 4,
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata
);
   timeunit 1ns; timeprecision 1ps;

   localparam int WORDS = 1 << AW;

   if (AW < 1 || AW > 10) begin : g_bad_aw
      $error("word_store: AW out of range 1..10");
   end

   logic [DW-1:0] cell_q [WORDS];

   for (genvar w = 0; w < WORDS; w++) begin : g_cell
      always_ff @(posedge clk) begin
         if (!rst_n)                          cell_q[w] <= '0;
         else if (we && addr == AW'(w))       cell_q[w] <= wdata;
      end
   end

   assign rdata = cell_q[addr];
endmodule

// File: rtl/resv_mem_front.sv
// Shared memory front end with load-linked / store-conditional monitoring.
module resv_mem_front
   import resv_pkg::*;
#(
   parameter int N_REQ       = 4,
   parameter int ADDR_W      = 4,
   parameter int DATA_W      = 32,
   parameter int SC_WAIT     = 3,
   parameter bit ROUND_ROBIN = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [N_REQ-1:0]         req_valid,
   output logic [N_REQ-1:0]         req_ready,
   input  logic [2*N_REQ-1:0]       req_op,
   input  logic [N_REQ*ADDR_W-1:0]  req_addr,
   input  logic [N_REQ*DATA_W-1:0]  req_wdata,
   output logic [N_REQ-1:0]         rsp_valid,
   output logic [DATA_W-1:0]        rsp_data
);
   timeunit 1ns; timeprecision 1ps;

   localparam int IW = (N_REQ > 1) ? $clog2(N_REQ) : 1;
   localparam int CW = $clog2(SC_WAIT + 1);

   if (SC_WAIT < 1)  begin : g_bad_wait  $error("SC_WAIT must be >= 1"); end
   if (DATA_W < 2)   begin : g_bad_dw    $error("DATA_W must be >= 2"); end
   if (N_REQ < 2)    begin : g_bad_n     $error("N_REQ must be >= 2"); end

   // ---------------- acceptance ----------------
   logic              idle_q;
   logic [CW-1:0]     cnt_q;
   logic [N_REQ-1:0]  arb_req;
   logic              hs;

   assign arb_req = (rst_n && idle_q) ? req_valid : '0;
   assign hs      = |req_ready;

   grant_rr #(.N(N_REQ), .ROUND_ROBIN(ROUND_ROBIN)) u_arb (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (arb_req),
      .adv   (hs),
      .gnt   (req_ready)
   );

   // winner's request fields
   logic [IW-1:0]     w_id;
   opc_e              w_op;
   logic [ADDR_W-1:0] w_addr;
   logic [DATA_W-1:0] w_data;

   always_comb begin
      w_id = '0;
      for (int k = 0; k < N_REQ; k++) begin
         if (req_ready[k]) w_id = IW'(k);
      end
   end

   always_comb begin
      w_op   = opc_e'(req_op[int'(w_id)*2 +: 2]);
      w_addr = req_addr[int'(w_id)*ADDR_W +: ADDR_W];
      w_data = req_wdata[int'(w_id)*DATA_W +: DATA_W];
   end

   // ---------------- conditional store hold ----------------
   logic [IW-1:0]     h_id_q;
   logic [ADDR_W-1:0] h_addr_q;
   logic [DATA_W-1:0] h_data_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idle_q   <= 1'b1;
         cnt_q    <= '0;
         h_id_q   <= '0;
         h_addr_q <= '0;
         h_data_q <= '0;
      end else if (hs && w_op == OPC_COND) begin
         idle_q   <= 1'b0;
         cnt_q    <= CW'(SC_WAIT - 1);
         h_id_q   <= w_id;
         h_addr_q <= w_addr;
         h_data_q <= w_data;
      end else if (!idle_q) begin
         if (cnt_q == '0) idle_q <= 1'b1;
         else             cnt_q  <= cnt_q - 1'b1;
      end
   end

   // ---------------- perform stage ----------------
   logic              pf_go;
   logic [IW-1:0]     pf_id;
   opc_e              pf_op;
   logic [ADDR_W-1:0] pf_addr;
   logic [DATA_W-1:0] pf_data;
   logic              sc_pass;
   logic              mem_we;
   logic [DATA_W-1:0] mem_rd;

   assign pf_go = (hs && w_op != OPC_COND) || (!idle_q && cnt_q == '0);

   always_comb begin
      if (idle_q) begin
         pf_id   = w_id;
         pf_op   = w_op;
         pf_addr = w_addr;
         pf_data = w_data;
      end else begin
         pf_id   = h_id_q;
         pf_op   = OPC_COND;
         pf_addr = h_addr_q;
         pf_data = h_data_q;
      end
   end

   resv_table #(.N(N_REQ), .AW(ADDR_W), .IW(IW)) u_resv (
      .clk   (clk),
      .rst_n (rst_n),
      .go    (pf_go),
      .id    (pf_id),
      .op    (pf_op),
      .addr  (pf_addr),
      .pass  (sc_pass)
   );

   assign mem_we = pf_go && ((pf_op == OPC_STORE) || (pf_op == OPC_COND && sc_pass));

   word_store #(.AW(ADDR_W), .DW(DATA_W)) u_mem (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (mem_we),
      .addr  (pf_addr),
      .wdata (pf_data),
      .rdata (mem_rd)
   );

   // ---------------- response ----------------
   logic [N_REQ-1:0]  rv_d;
   logic [DATA_W-1:0] rd_d;
   logic              rsp_sc_q;

   always_comb begin
      rv_d = '0;
      if (pf_go) rv_d[pf_id] = 1'b1;
      case (pf_op)
         OPC_LOAD, OPC_LINK: rd_d = mem_rd;
         OPC_COND:           rd_d = DATA_W'(sc_pass);
         default:            rd_d = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= '0;
         rsp_data  <= '0;
         rsp_sc_q  <= 1'b0;
      end else begin
         rsp_valid <= rv_d;
         rsp_data  <= pf_go ? rd_d : '0;
         rsp_sc_q  <= pf_go && (pf_op == OPC_COND);
      end
   end

   // ---------------- assertions ----------------
   a_r8_ready_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(req_ready));
   a_r8_ready_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
      (req_ready & ~req_valid) == '0);
   a_r9_cond_stalls: assert property (@(posedge clk) disable iff (!rst_n)
      (hs && w_op == OPC_COND) |=> (req_ready == '0 && rsp_valid == '0));
   a_r1_rsp_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(rsp_valid));
   a_r3_status_is_bit: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_sc_q && rsp_valid != '0) |-> (rsp_data[DATA_W-1:1] == '0));

   always @(posedge clk) begin
      if (!rst_n) begin
         a_r10_no_ready_in_reset: assert (req_ready == '0);
      end
   end
endmodule

// File: tb/sim_resv_mem_front.sv
module sim_resv_mem_front;
   timeunit 1ns; timeprecision 1ps;

   localparam int N     = 4;
   localparam int AW    = 4;
   localparam int DW    = 32;
   localparam int W     = 3;
   localparam int WORDS = 1 << AW;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic [N-1:0]    b_valid = '0;
   logic [1:0]      b_op   [N];
   logic [AW-1:0]   b_addr [N];
   logic [DW-1:0]   b_data [N];
   logic [N-1:0]    req_ready, rsp_valid;
   logic [2*N-1:0]  req_op;
   logic [N*AW-1:0] req_addr;
   logic [N*DW-1:0] req_wdata;
   logic [DW-1:0]   rsp_data;

   for (genvar g = 0; g < N; g++) begin : g_pack
      assign req_op[2*g +: 2]     = b_op[g];
      assign req_addr[AW*g +: AW] = b_addr[g];
      assign req_wdata[DW*g +: DW] = b_data[g];
   end

   resv_mem_front #(.N_REQ(N), .ADDR_W(AW), .DATA_W(DW), .SC_WAIT(W)) u0 (
      .clk(clk), .rst_n(rst_n),
      .req_valid(b_valid), .req_ready(req_ready),
      .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit ended = 0;

   // ---------------- reference model ----------------
   logic [DW-1:0] m_mem [WORDS];
   bit            m_v   [N];
   logic [AW-1:0] m_a   [N];
   int            m_last;
   logic [DW-1:0] r_got [N];

   task automatic model_reset();
      for (int i = 0; i < WORDS; i++) m_mem[i] = '0;
      for (int i = 0; i < N; i++) begin m_v[i] = 0; m_a[i] = '0; end
      m_last = N - 1;
   endtask

   function automatic logic [N-1:0] oh(int i);
      logic [N-1:0] v = '0;
      v[i] = 1'b1;
      return v;
   endfunction

   function automatic int model_pick(logic [N-1:0] pend);
      for (int k = 1; k <= N; k++) begin
         if (pend[(m_last + k) % N]) return (m_last + k) % N;
      end
      return 0;
   endfunction

   task automatic clear_others(int id, logic [AW-1:0] a);
      for (int i = 0; i < N; i++) begin
         if (i != id && m_v[i] && m_a[i] == a) m_v[i] = 0;
      end
   endtask

   task automatic model_exec(input int id, input int op, input logic [AW-1:0] a,
                             input logic [DW-1:0] d, output logic [DW-1:0] exp,
                             output string tag);
      case (op)
         0: begin exp = m_mem[a]; tag = "R1"; end
         1: begin exp = '0; m_mem[a] = d; clear_others(id, a); tag = "R6"; end
         2: begin exp = m_mem[a]; m_v[id] = 1; m_a[id] = a; tag = "R2"; end
         default: begin
            if (m_v[id] && m_a[id] == a) begin
               exp = 1; m_mem[a] = d; clear_others(id, a); tag = "R3";
            end else begin
               exp = 0; tag = "R4";
            end
            m_v[id] = 0;
         end
      endcase
   endtask

   task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0h expected %0h", tag, act, exp);
      end
   endtask

   // Present a set of requests at once; called at a falling edge.
   task automatic run_set(input logic [N-1:0] mask);
      logic [N-1:0] pend;
      int w, op;
      logic [DW-1:0] exp;
      string tag;
      bit bad;
      pend = mask; b_valid = mask; bad = 0;
      while (pend != '0 && !bad) begin
         #1;
         w = model_pick(pend);
         chk("R8", req_ready, oh(w));
         if (req_ready !== oh(w)) begin
            bad = 1; b_valid = '0; @(negedge clk);
         end else begin
            op = int'(b_op[w]);
            model_exec(w, op, b_addr[w], b_data[w], exp, tag);
            m_last = w;
            @(posedge clk); #1;
            b_valid[w] = 1'b0; pend[w] = 1'b0;
            @(negedge clk);
            if (op == 3) begin
               for (int k = 0; k < W; k++) begin
                  chk("R9", rsp_valid, '0);
                  chk("R9", req_ready, '0);
                  @(negedge clk);
               end
            end
            chk(tag, rsp_valid, oh(w));
            chk(tag, rsp_data, exp);
            r_got[w] = rsp_data;
         end
      end
   endtask

   task automatic single(int id, int op, int a, logic [DW-1:0] d);
      b_op[id] = 2'(op); b_addr[id] = AW'(a); b_data[id] = d;
      run_set(oh(id));
   endtask

   task automatic do_reset();
      for (int i = 0; i < N; i++) begin b_op[i] = 2'd0; b_addr[i] = '0; b_data[i] = '0; end
      b_valid = '1; rst_n = 1'b0;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk); #1;
         chk("R10", req_ready, '0);
      end
      b_valid = '0;
      @(negedge clk);
      rst_n = 1'b1;
      model_reset();
      @(negedge clk);
   endtask

   task automatic mutex_run();
      bit done [N];
      int acq = 0;
      int rounds = 0;
      for (int i = 0; i < N; i++) done[i] = 0;
      while (acq < N && rounds < 3 * N) begin
         logic [N-1:0] m, s;
         int wins, who;
         rounds++;
         m = '0;
         for (int i = 0; i < N; i++) begin
            if (!done[i]) begin
               m[i] = 1'b1; b_op[i] = 2'd2; b_addr[i] = '0; b_data[i] = '0;
            end
         end
         run_set(m);
         s = '0;
         for (int i = 0; i < N; i++) begin
            if (m[i] && r_got[i] == '0) begin
               s[i] = 1'b1; b_op[i] = 2'd3; b_data[i] = 1;
            end
         end
         if (s != '0) begin
            run_set(s);
            wins = 0; who = 0;
            for (int i = 0; i < N; i++) begin
               if (s[i] && r_got[i] == 1) begin wins++; who = i; end
            end
            chk("R11", wins, 1);
            if (wins >= 1) begin
               done[who] = 1; acq++;
               single(who, 1, 0, '0);
            end
         end
      end
      chk("R11", acq, N);
   endtask

   // ---------------- stimulus ----------------
   initial begin
      int unsigned seed_dummy;
      seed_dummy = $urandom(32'd20240611);
      for (int i = 0; i < N; i++) begin b_op[i] = '0; b_addr[i] = '0; b_data[i] = '0; r_got[i] = '0; end
      model_reset();
      @(negedge clk);
      do_reset();

      // R10: memory cleared
      single(0, 0, 5, '0);
      chk("R10", r_got[0], 0);

      // R1: store then load from another requester
      single(0, 1, 5, 32'hA5A5_0001);
      single(1, 0, 5, '0);
      chk("R1", r_got[1], 32'hA5A5_0001);

      // R2 / R3: link then successful conditional
      single(1, 2, 5, '0);
      chk("R2", r_got[1], 32'hA5A5_0001);
      single(1, 3, 5, 32'h0000_BEEF);
      chk("R3", r_got[1], 1);
      single(2, 0, 5, '0);
      chk("R3", r_got[2], 32'h0000_BEEF);

      // R5: repeated conditional fails, memory unchanged
      single(1, 3, 5, 32'h1111_1111);
      chk("R5", r_got[1], 0);
      single(2, 0, 5, '0);
      chk("R5", r_got[2], 32'h0000_BEEF);

      // R4: no reservation, and mismatched address
      single(2, 3, 6, 32'h2222_2222);
      chk("R4", r_got[2], 0);
      single(2, 2, 6, '0);
      single(2, 3, 7, 32'h3333_3333);
      chk("R4", r_got[2], 0);
      single(3, 0, 7, '0);
      chk("R4", r_got[3], 0);

      // R6: another requester's store kills both reservations
      single(0, 2, 3, '0);
      single(1, 2, 3, '0);
      single(2, 1, 3, 32'h44);
      single(0, 3, 3, 32'h55);
      chk("R6", r_got[0], 0);
      single(1, 3, 3, 32'h66);
      chk("R6", r_got[1], 0);
      // R6: a winning conditional kills the other one
      single(0, 2, 3, '0);
      single(1, 2, 3, '0);
      single(0, 3, 3, 32'h77);
      chk("R6", r_got[0], 1);
      single(1, 3, 3, 32'h88);
      chk("R6", r_got[1], 0);
      // R6: own plain store keeps own reservation
      single(2, 2, 9, '0);
      single(2, 1, 9, 32'h99);
      single(2, 3, 9, 32'h9A);
      chk("R6", r_got[2], 1);

      // R7: newer link replaces older
      single(3, 2, 1, '0);
      single(3, 2, 2, '0);
      single(3, 3, 1, 32'hC1);
      chk("R7", r_got[3], 0);
      single(3, 2, 1, '0);
      single(3, 2, 2, '0);
      single(3, 3, 2, 32'hC2);
      chk("R7", r_got[3], 1);

      // R8: four simultaneous loads, rotating order checked in run_set
      for (int i = 0; i < N; i++) begin b_op[i] = 2'd0; b_addr[i] = AW'(i); end
      run_set('1);
      for (int i = 0; i < N; i++) begin b_op[i] = 2'd0; b_addr[i] = AW'(9); end
      run_set(4'b1010);

      // R10: reset disarms a reservation
      single(0, 2, 2, '0);
      do_reset();
      single(0, 3, 2, 32'hDD);
      chk("R10", r_got[0], 0);

      // R11: mutex contention
      mutex_run();

      // random mixed traffic on a narrow address range
      for (int it = 0; it < 300; it++) begin
         logic [N-1:0] mk;
         mk = N'($urandom % (1 << N));
         if (mk == '0) mk = oh(int'($urandom % N));
         for (int i = 0; i < N; i++) begin
            b_op[i]   = 2'($urandom % 4);
            b_addr[i] = AW'($urandom % 4);
            b_data[i] = $urandom;
         end
         run_set(mk);
      end

      if (!ended) begin
         ended = 1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!ended) begin
         ended = 1;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule